// File: doc/BRIEF.md
# Core Status Register with Masked Writes

This block holds the 8-bit status word of a small accumulator-style processor core. Three kinds of source can change it. The first is an ordinary data write, from an instruction whose destination is the status word. The second is a set of flag updates from the ALU for the zero, digit-carry and carry flags. The third is a pair of set/clear strobes from the reset controller for the watchdog-timeout and power-down cause bits. A data write is only partly effective. The cause bits ignore it completely. The three arithmetic flags ignore it whenever the same instruction also produces ALU flags.

Each flag has its own "affects" input, so an instruction can update a subset of the flags. Flags that the instruction does not affect keep their previous value. This makes it possible to express a clear-to-zero aimed at the status word: the bank bits are written with zero, the zero flag is set by the ALU, and the cause bits, digit carry and carry stay as they were. The three bank-select bits also appear on a separate output for the data-memory address path.

Top module: `status_reg`

## Requirements
- R1: A cycle with `rst` high leaves `status_q` at 8'h18 on the following cycle: bank bits 0, timeout and power-down bits 1, flags 0. Bit layout from MSB to LSB: bank[2], bank[1], bank[0], timeout (bit 4), power-down (bit 3), Z (bit 2), DC (bit 1), C (bit 0).
- R2: With `wr_en` high and `flag_aff` all zero, the next `status_q` takes bits 7:5 and 2:0 from `wr_data`.
- R3: A data write never changes bits 4:3. Those bits change only through the four cause strobes.
- R4: For each flag whose `flag_aff` bit is high (bit 2 = Z, bit 1 = DC, bit 0 = C), the flag takes the matching `alu_flags` bit on the next cycle, whether or not `wr_en` is high.
- R5: With `wr_en` high and any `flag_aff` bit high, no `wr_data` bit reaches Z, DC or C. The flags whose `flag_aff` bit is low keep their value.
- R6: A set strobe forces its cause bit to 1 and a clear strobe forces it to 0. When both strobes are high in the same cycle, set wins.
- R7: `bank_sel` always equals `status_q[7:5]`. It changes only on a data write.
- R8: A write of 8'h00 together with `flag_aff` = 3'b100 and `alu_flags[2]` = 1 leaves the pattern 000uu1uu, where u is the previous value.
- R9: With `wr_en` low, the flags whose `flag_aff` bit is high still take their ALU values, and the other bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Data write to the status word |
| wr_data | input | 8 | Data write value |
| flag_aff | input | 3 | Per-flag ALU update enables {Z, DC, C} |
| alu_flags | input | 3 | ALU-produced flag values {Z, DC, C} |
| tmo_set | input | 1 | Set the timeout cause bit |
| tmo_clr | input | 1 | Clear the timeout cause bit |
| pwd_set | input | 1 | Set the power-down cause bit |
| pwd_clr | input | 1 | Clear the power-down cause bit |
| status_q | output | 8 | Current status word |
| bank_sel | output | 3 | Bank-select bits (status bits 7:5) |

## Verification
The assertions treat every input as a free synchronous signal that is stable at the clock edge. They expect no ordering between sources, so writes, flag updates and both strobes of a pair can all be high in the same cycle. The stimulus changes inputs only on the falling edge. A sweep over every write value, every subset of flag enables and both write-enable values also drives conflicting strobe pairs. Together with the directed cases, this keeps all legal input combinations inside the range the properties cover.

// File: rtl/status_pkg.sv
package status_pkg;

    localparam int STAT_W   = 8;
    localparam int BANK_W   = 3;
    localparam int CAUSE_W  = 2;
    localparam int FLAG_W   = 3;
    localparam int BANK_LSB = STAT_W - BANK_W;
    localparam int CAUSE_LSB = FLAG_W;

    typedef struct packed {
        logic zf;
        logic dcf;
        logic cf;
    } flags_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              tmo;
        logic              pwd;
        flags_t            flags;
    } status_t;

    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_DATA = 2'd1,
        SRC_ALU  = 2'd2
    } flag_src_e;

    localparam status_t STAT_RST = '{bank: '0, tmo: 1'b1, pwd: 1'b1, flags: '0};

    function automatic flag_src_e pick_src(input logic aff_bit,
                                           input logic wr,
                                           input logic any_aff);
        if (aff_bit)
            return SRC_ALU;
        else if (wr && !any_aff)
            return SRC_DATA;
        else
            return SRC_HOLD;
    endfunction

    function automatic logic cause_next(input logic cur,
                                        input logic set_s,
                                        input logic clr_s);
        if (set_s)
            return 1'b1;
        else if (clr_s)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/status_flag_unit.sv
module status_flag_unit
    import status_pkg::*;
#(
    parameter int W = FLAG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_bits,
    input  logic [W-1:0] aff,
    input  logic [W-1:0] alu,
    output logic [W-1:0] flag_q
);

    logic any_aff;
    assign any_aff = |aff;

    for (genvar i = 0; i < W; i++) begin : g_flag
        flag_src_e src;
        logic      bit_q;

        always_comb src = pick_src(aff[i], wr_en, any_aff);

        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else begin
                case (src)
                    SRC_ALU:  bit_q <= alu[i];
                    SRC_DATA: bit_q <= wr_bits[i];
                    default:  bit_q <= bit_q;
                endcase
            end
        end

        assign flag_q[i] = bit_q;
    end

endmodule

// File: rtl/status_cause_unit.sv
module status_cause_unit
    import status_pkg::*;
#(
    parameter int N = CAUSE_W,
    parameter logic [N-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_s,
    input  logic [N-1:0] clr_s,
    output logic [N-1:0] cause_q
);

    for (genvar i = 0; i < N; i++) begin : g_cause
        logic bit_q;

        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= RST_VAL[i];
            else
                bit_q <= cause_next(bit_q, set_s[i], clr_s[i]);
        end

        assign cause_q[i] = bit_q;
    end

endmodule

// File: rtl/status_bank_unit.sv
module status_bank_unit
    import status_pkg::*;
#(
    parameter int W = BANK_W,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_bits,
    output logic [W-1:0] bank_q
);

    always_ff @(posedge clk) begin
        if (rst)
            bank_q <= RST_VAL;
        else if (wr_en)
            bank_q <= wr_bits;
    end

endmodule

// File: rtl/status_reg.sv
module status_reg
    import status_pkg::*;
#(
    parameter logic [BANK_W-1:0] BANK_RST = STAT_RST.bank
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic [FLAG_W-1:0] flag_aff,
    input  logic [FLAG_W-1:0] alu_flags,
    input  logic              tmo_set,
    input  logic              tmo_clr,
    input  logic              pwd_set,
    input  logic              pwd_clr,
    output logic [STAT_W-1:0] status_q,
    output logic [BANK_W-1:0] bank_sel
);

    status_t            wd;
    status_t            cur;
    logic [BANK_W-1:0]  bank_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [FLAG_W-1:0]  flag_q;

    assign wd = status_t'(wr_data);

    status_bank_unit #(
        .W       (BANK_W),
        .RST_VAL (BANK_RST)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_bits (wd.bank),
        .bank_q  (bank_q)
    );

    status_cause_unit #(
        .N       (CAUSE_W),
        .RST_VAL ({STAT_RST.tmo, STAT_RST.pwd})
    ) u_cause (
        .clk     (clk),
        .rst     (rst),
        .set_s   ({tmo_set, pwd_set}),
        .clr_s   ({tmo_clr, pwd_clr}),
        .cause_q (cause_q)
    );

    status_flag_unit #(
        .W (FLAG_W)
    ) u_flags (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_bits (wd.flags),
        .aff     (flag_aff),
        .alu     (alu_flags),
        .flag_q  (flag_q)
    );

    always_comb begin
        cur.bank  = bank_q;
        cur.tmo   = cause_q[1];
        cur.pwd   = cause_q[0];
        cur.flags = flag_q;
    end

    assign status_q = cur;
    assign bank_sel = bank_q;

endmodule

// File: rtl/status_reg_chk.sv
module status_reg_chk
    import status_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [STAT_W-1:0] wr_data,
    input logic [FLAG_W-1:0] flag_aff,
    input logic [FLAG_W-1:0] alu_flags,
    input logic              tmo_set,
    input logic              tmo_clr,
    input logic              pwd_set,
    input logic              pwd_clr,
    input logic [STAT_W-1:0] status_q,
    input logic [BANK_W-1:0] bank_sel
);

    p_reset_val_r1: assert property (@(posedge clk)
        rst |=> (status_q == 8'h18));

    p_data_flags_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && flag_aff == '0) |=> (status_q[2:0] == $past(wr_data[2:0])));

    p_cause_ro_r3: assert property (@(posedge clk) disable iff (rst)
        (!tmo_set && !tmo_clr && !pwd_set && !pwd_clr)
        |=> (status_q[4:3] == $past(status_q[4:3])));

    p_alu_load_r4: assert property (@(posedge clk) disable iff (rst)
        (|flag_aff) |=> ((status_q[2:0] & $past(flag_aff)) ==
                         ($past(alu_flags) & $past(flag_aff))));

    p_wr_block_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && |flag_aff) |=> ((status_q[2:0] & ~$past(flag_aff)) ==
                                  ($past(status_q[2:0]) & ~$past(flag_aff))));

    p_tmo_set_r6: assert property (@(posedge clk) disable iff (rst)
        tmo_set |=> status_q[4]);

    p_pwd_set_r6: assert property (@(posedge clk) disable iff (rst)
        pwd_set |=> status_q[3]);

    p_tmo_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (tmo_clr && !tmo_set) |=> !status_q[4]);

    p_pwd_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (pwd_clr && !pwd_set) |=> !status_q[3]);

    p_bank_write_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (bank_sel == $past(wr_data[7:5])));

    p_bank_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(bank_sel));

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> ((status_q[2:0] & ~$past(flag_aff)) ==
                      ($past(status_q[2:0]) & ~$past(flag_aff))));

endmodule

bind status_reg status_reg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .flag_aff  (flag_aff),
    .alu_flags (alu_flags),
    .tmo_set   (tmo_set),
    .tmo_clr   (tmo_clr),
    .pwd_set   (pwd_set),
    .pwd_clr   (pwd_clr),
    .status_q  (status_q),
    .bank_sel  (bank_sel)
);

// File: tb/sim_status_reg.sv
`timescale 1ns/1ps
module sim_status_reg;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] flag_aff = '0;
    logic [2:0] alu_flags = '0;
    logic       tmo_set = 1'b0, tmo_clr = 1'b0, pwd_set = 1'b0, pwd_clr = 1'b0;
    logic [7:0] status_q;
    logic [2:0] bank_sel;

    int   n_tests = 0;
    int   n_fail  = 0;
    logic [7:0] exp_q;

    always #4 clk = ~clk;

    status_reg u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .flag_aff(flag_aff), .alu_flags(alu_flags),
        .tmo_set(tmo_set), .tmo_clr(tmo_clr), .pwd_set(pwd_set), .pwd_clr(pwd_clr),
        .status_q(status_q), .bank_sel(bank_sel)
    );

    // Expected next value, built from the requirements
    function automatic logic [7:0] model(input logic [7:0] q, input logic we,
                                         input logic [7:0] d, input logic [2:0] aff,
                                         input logic [2:0] alu, input logic ts,
                                         input logic tc, input logic ps, input logic pc);
        logic [7:0] n;
        n = q;
        if (we) n[7:5] = d[7:5];
        n[4] = ts ? 1'b1 : (tc ? 1'b0 : q[4]);
        n[3] = ps ? 1'b1 : (pc ? 1'b0 : q[3]);
        for (int i = 0; i < 3; i++) begin
            if (aff[i]) n[i] = alu[i];
            else if (we && aff == 3'b000) n[i] = d[i];
        end
        return n;
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] d, input logic [2:0] aff,
                        input logic [2:0] alu, input logic ts, input logic tc,
                        input logic ps, input logic pc);
        wr_en = we; wr_data = d; flag_aff = aff; alu_flags = alu;
        tmo_set = ts; tmo_clr = tc; pwd_set = ps; pwd_clr = pc;
        exp_q = model(exp_q, we, d, aff, alu, ts, tc, ps, pc);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_q = 8'h18;
        check("R1 reset value", status_q, 8'h18);
        check("R7 bank output after reset", {5'b0, bank_sel}, 8'h00);

        // R2: plain write of every bit
        step(1'b1, 8'hE7, 3'b000, 3'b000, 0, 0, 0, 0);
        check("R2 plain write", status_q, 8'hFF);
        check("R7 bank output follows write", {5'b0, bank_sel}, 8'h07);

        // R8: clear-to-zero pattern 000uu1uu
        step(1'b1, 8'h00, 3'b100, 3'b100, 0, 0, 0, 0);
        check("R8 clear-to-zero", status_q, 8'h1F);

        // R9: flag update without write
        step(1'b0, 8'hFF, 3'b011, 3'b010, 0, 0, 0, 0);
        check("R9 alu update without write", status_q, 8'h1E);
        check("R7 bank holds without write", {5'b0, bank_sel}, 8'h00);

        // R6: strobe priority
        step(1'b0, 8'h00, 3'b000, 3'b000, 0, 1, 0, 1);
        check("R6 both clears", status_q, 8'h06);
        step(1'b0, 8'h00, 3'b000, 3'b000, 1, 1, 1, 1);
        check("R6 set wins over clear", status_q, 8'h1E);
        step(1'b0, 8'h00, 3'b000, 3'b000, 0, 1, 0, 0);
        check("R6 timeout clear only", status_q, 8'h0E);

        // R3: a write of ones cannot set a cleared cause bit
        step(1'b1, 8'hFF, 3'b000, 3'b000, 0, 0, 0, 0);
        check("R3 write does not touch cause bits", status_q, 8'hEF);
        step(1'b1, 8'h00, 3'b000, 3'b000, 0, 0, 0, 0);
        check("R3 write zero keeps power-down", status_q, 8'h08);

        // R4/R5: write combined with ALU update of DC only
        step(1'b1, 8'hFF, 3'b010, 3'b010, 0, 0, 0, 0);
        check("R4 DC from alu, R5 Z and C blocked", status_q, 8'hEA);

        // Near-exhaustive sweep
        for (int we = 0; we < 2; we++) begin
            for (int aff = 0; aff < 8; aff++) begin
                for (int d = 0; d < 256; d++) begin
                    logic [3:0] stb;
                    logic [2:0] alu;
                    stb = (d[2:0] == 3'b101) ? d[7:4] : 4'b0000;
                    alu = 3'((d * 5 + aff) & 7);
                    step(we[0], d[7:0], aff[2:0], alu, stb[3], stb[2], stb[1], stb[0]);
                    check("R2 bank field", {5'b0, status_q[7:5]}, {5'b0, exp_q[7:5]});
                    check("R3 cause field", {6'b0, status_q[4:3]}, {6'b0, exp_q[4:3]});
                    if (aff != 0)
                        check("R5 flags with alu update", {5'b0, status_q[2:0]}, {5'b0, exp_q[2:0]});
                    else
                        check("R2 flags from data", {5'b0, status_q[2:0]}, {5'b0, exp_q[2:0]});
                    check("R7 bank output", {5'b0, bank_sel}, {5'b0, exp_q[7:5]});
                end
            end
        end

        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset after activity", status_q, 8'h18);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule